// File: doc/BRIEF.md
# Colour Subcarrier Phase Generator

This block is a numerically controlled oscillator for the chroma path of an analog television encoder that runs at 27 MHz. A 32-bit phase accumulator adds a programmable increment on every clock. The increment equals fsc / fclk × 2^32. The default after reset is 0x21F07C1F, which gives the 525-line subcarrier. The 625-line subcarrier uses 0x2A098ACB. The upper accumulator bits go out as a phase word, which a sine lookup outside the block turns into a carrier.

Software writes the increment one byte at a time. Bytes 3, 2 and 1 wait in a staging register. A write to byte 0 moves the whole word into the accumulator path in one step. The block also counts fields from a field strobe and offers four policies that force the phase back to zero, tied to line or field cadence. It reports the field sequence count, an odd/even flag, and a pulse that marks the start of each 4- or 8-field cycle.

Top module: `sc_dds`

## Requirements
- R1: While `rst_ni` is low, the outputs are: `phase_o` = 0, `fseq_o` = 0, `odd_even_o` = 0, `seq_pulse_o` = 0. After reset the active increment is 0x21F07C1F.
- R2: On every rising clock edge that clears nothing, the 32-bit accumulator advances by the active increment, modulo 2^32. `phase_o` shows accumulator bits [31:22].
- R3: `byte_sel_i` picks a byte: 3 is the most significant, 0 the least. A write to byte 3, 2 or 1 only updates the staging register and leaves the accumulation unchanged. A write to byte 0 loads {staged 3, staged 2, staged 1, written byte} as the active increment. The edge that takes the write still adds the old increment; every later edge adds the new one.
- R4: When `rst_mode_i` = 00, line and field strobes never clear the accumulator.
- R5: When `rst_mode_i` = 01, the accumulator is zero after every second line strobe. A line parity bit starts at 0 after reset and toggles on every line strobe. A line strobe taken while the bit is 1 qualifies.
- R6: When `rst_mode_i` = 10, a field strobe taken while the internal 3-bit field count is 7 clears the accumulator, so the clear comes every eighth field.
- R7: When `rst_mode_i` = 11, a field strobe taken while the low two bits of the field count are 11 clears the accumulator, so the clear comes every fourth field.
- R8: Each field strobe advances the 3-bit field count modulo 8. `fseq_o` shows the full count when `seq4_i` = 0, and {0, count[1:0]} (modulo 4) when `seq4_i` = 1.
- R9: `odd_even_o` equals `fseq_o[0]`: 0 means an odd field, 1 an even field.
- R10: `seq_pulse_o` is high for one cycle after a field strobe that wraps `fseq_o` to 0. With `seq4_i` = 1 that is every fourth field; with `seq4_i` = 0 every eighth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27 MHz pixel clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| byte_we_i | input | 1 | Increment byte write strobe |
| byte_sel_i | input | 2 | Byte index, 3 = most significant |
| byte_data_i | input | 8 | Byte value to write |
| rst_mode_i | input | 2 | Phase reset policy: 00 none, 01 two lines, 10 eight fields, 11 four fields |
| seq4_i | input | 1 | 1 = 4-field sequence, 0 = 8-field sequence |
| line_stb_i | input | 1 | One-cycle line start strobe |
| field_stb_i | input | 1 | One-cycle field start strobe |
| phase_o | output | 10 | Accumulator bits [31:22] |
| fseq_o | output | 3 | Field sequence count |
| odd_even_o | output | 1 | 0 odd field, 1 even field |
| seq_pulse_o | output | 1 | Start-of-sequence pulse |

## Verification
The bench targets these corner cases:

- **Staged increment.** Bytes 3 to 1 are written and then left idle for several cycles before byte 0 arrives. A design that applied partial bytes would show a phase slope that changes too early.
- **Line-pair clear.** A design with the wrong parity start or polarity would clear on odd-numbered line strobes, one line off.
- **Field-count clears.** Runs over more than one full 4- and 8-field cycle would expose a clear tied to the wrong count value.
- **Sequence views.** These runs also check the modulo-4 view and the single-cycle sequence pulse.
- **Accumulator wrap.** A near-full increment forces wrap on every cycle. A design that saturated the accumulator, or kept a carry, would show the wrong top bits.

// File: rtl/sc_dds_pkg.sv
package sc_dds_pkg;
  typedef enum logic [1:0] {
    PR_NONE   = 2'd0,
    PR_LINE2  = 2'd1,
    PR_FIELD8 = 2'd2,
    PR_FIELD4 = 2'd3
  } prst_mode_e;

  localparam int BYTE_W = 8;
endpackage

// File: rtl/sc_incr_reg.sv
module sc_incr_reg #(
  parameter int              ACC_W   = 32,
  parameter logic [ACC_W-1:0] RST_VAL = 32'h21F07C1F,
  parameter int              SEL_W   = $clog2(ACC_W/8)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic [7:0]       data_i,
  output logic [ACC_W-1:0] incr_o
);
  localparam int NB = ACC_W / sc_dds_pkg::BYTE_W;

  logic [ACC_W-1:8] shadow_q;
  logic [ACC_W-1:0] incr_q;
  logic             commit;

  assign commit = we_i && (sel_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shadow_q <= '0;
    end else if (we_i) begin
      for (int b = 1; b < NB; b++) begin
        if (sel_i == SEL_W'(b)) shadow_q[b*8 +: 8] <= data_i;
      end
    end
  end

  // whole word moves at once on the low byte write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     incr_q <= RST_VAL;
    else if (commit) incr_q <= {shadow_q, data_i};
  end

  assign incr_o = incr_q;

  AST_INCR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable(incr_q)); // R3
  AST_INCR_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit |=> incr_q[7:0] == $past(data_i)); // R3
endmodule

// File: rtl/sc_field_seq.sv
module sc_field_seq #(
  parameter int FSEQ_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              line_stb_i,
  input  logic              field_stb_i,
  input  logic [1:0]        mode_i,
  input  logic              seq4_i,
  output logic              clr_o,
  output logic [FSEQ_W-1:0] fseq_o,
  output logic              pulse_o
);
  import sc_dds_pkg::*;

  localparam int SHORT_W = FSEQ_W - 1;

  prst_mode_e        mode;
  logic              lpar_q;
  logic [FSEQ_W-1:0] cnt_q;
  logic              pulse_q;
  logic              at_full, at_short, wrap;

  assign mode     = prst_mode_e'(mode_i);
  assign at_full  = (cnt_q == '1);
  assign at_short = (cnt_q[SHORT_W-1:0] == '1);
  assign wrap     = field_stb_i && (seq4_i ? at_short : at_full);

  always_comb begin
    unique case (mode)
      PR_LINE2:  clr_o = line_stb_i && lpar_q;
      PR_FIELD8: clr_o = field_stb_i && at_full;
      PR_FIELD4: clr_o = field_stb_i && at_short;
      default:   clr_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lpar_q  <= 1'b0;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      if (line_stb_i)  lpar_q <= !lpar_q;
      if (field_stb_i) cnt_q  <= cnt_q + FSEQ_W'(1);
      pulse_q <= wrap;
    end
  end

  assign fseq_o  = seq4_i ? {1'b0, cnt_q[SHORT_W-1:0]} : cnt_q;
  assign pulse_o = pulse_q;

  AST_NONE_NO_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == PR_NONE) |-> !clr_o); // R4
  AST_FLD_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    field_stb_i |=> cnt_q == $past(cnt_q) + FSEQ_W'(1)); // R8
  AST_FLD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !field_stb_i |=> $stable(cnt_q)); // R8
  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_o |=> !pulse_o); // R10
endmodule

// File: rtl/sc_phase_acc.sv
module sc_phase_acc #(
  parameter int ACC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [ACC_W-1:0] incr_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    acc_q <= '0;
    else if (clr_i) acc_q <= '0;
    else            acc_q <= acc_q + incr_i;
  end

  assign acc_o = acc_q;

  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> acc_q == $past(acc_q) + $past(incr_i)); // R2
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> acc_q == '0); // R5
endmodule

// File: rtl/sc_dds.sv
module sc_dds #(
  parameter int               ACC_W    = 32,
  parameter int               PH_W     = 10,
  parameter logic [ACC_W-1:0] RST_INCR = 32'h21F07C1F,
  parameter int               SEL_W    = $clog2(ACC_W/8),
  parameter int               FSEQ_W   = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_we_i,
  input  logic [SEL_W-1:0]  byte_sel_i,
  input  logic [7:0]        byte_data_i,
  input  logic [1:0]        rst_mode_i,
  input  logic              seq4_i,
  input  logic              line_stb_i,
  input  logic              field_stb_i,
  output logic [PH_W-1:0]   phase_o,
  output logic [FSEQ_W-1:0] fseq_o,
  output logic              odd_even_o,
  output logic              seq_pulse_o
);
  logic [ACC_W-1:0] incr, acc;
  logic             clr;

  sc_incr_reg #(.ACC_W(ACC_W), .RST_VAL(RST_INCR), .SEL_W(SEL_W)) u_incr (
    .clk_i, .rst_ni,
    .we_i   (byte_we_i),
    .sel_i  (byte_sel_i),
    .data_i (byte_data_i),
    .incr_o (incr)
  );

  sc_field_seq #(.FSEQ_W(FSEQ_W)) u_fseq (
    .clk_i, .rst_ni,
    .line_stb_i, .field_stb_i,
    .mode_i  (rst_mode_i),
    .seq4_i,
    .clr_o   (clr),
    .fseq_o,
    .pulse_o (seq_pulse_o)
  );

  sc_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk_i, .rst_ni,
    .clr_i  (clr),
    .incr_i (incr),
    .acc_o  (acc)
  );

  assign phase_o    = acc[ACC_W-1 -: PH_W];
  assign odd_even_o = fseq_o[0]; // 1 = even field

  AST_ODD_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    odd_even_o == fseq_o[0]); // R9
endmodule

// File: tb/sc_dds_test.sv
module sc_dds_test;
  localparam int PERIOD = 10;

  typedef struct {
    logic [9:0] ph;
    logic [2:0] fs;
    logic       oe;
    logic       pl;
    string      tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       byte_we = 1'b0;
  logic [1:0] byte_sel = '0;
  logic [7:0] byte_data = '0;
  logic [1:0] rst_mode = '0;
  logic       seq4 = 1'b0;
  logic       line_stb = 1'b0;
  logic       field_stb = 1'b0;
  logic [9:0] phase;
  logic [2:0] fseq;
  logic       odd_even, seq_pulse;

  int checks = 0;
  int fails  = 0;
  exp_t q[$];
  string cur_req = "R1";
  logic [1:0] cur_mode = 2'd0;
  logic       cur_seq4 = 1'b0;

  logic [31:0] m_acc, m_incr;
  logic [7:0]  m_sh [4];
  logic        m_lpar, m_pl;
  logic [2:0]  m_cnt;

  always #(PERIOD/2) clk = ~clk;

  sc_dds uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .byte_we_i(byte_we), .byte_sel_i(byte_sel), .byte_data_i(byte_data),
    .rst_mode_i(rst_mode), .seq4_i(seq4),
    .line_stb_i(line_stb), .field_stb_i(field_stb),
    .phase_o(phase), .fseq_o(fseq), .odd_even_o(odd_even), .seq_pulse_o(seq_pulse)
  );

  function automatic void push_exp();
    exp_t e;
    e.ph  = m_acc[31:22];
    e.fs  = cur_seq4 ? {1'b0, m_cnt[1:0]} : m_cnt;
    e.oe  = e.fs[0];
    e.pl  = m_pl;
    e.tag = cur_req;
    q.push_back(e);
  endfunction

  function automatic void model_reset();
    m_acc = '0; m_incr = 32'h21F07C1F; m_lpar = 1'b0; m_pl = 1'b0; m_cnt = '0;
    for (int i = 0; i < 4; i++) m_sh[i] = '0;
  endfunction

  task automatic rst_cycle();
    @(negedge clk); #1;
    rst_ni = 1'b0;
    @(posedge clk);
    model_reset();
    cur_req = "R1";
    push_exp();
  endtask

  task automatic drive(input logic lstb, input logic fstb, input logic we,
                       input logic [1:0] sel, input logic [7:0] d);
    logic clr;
    @(negedge clk); #1;
    rst_ni = 1'b1;
    line_stb = lstb; field_stb = fstb; byte_we = we; byte_sel = sel; byte_data = d;
    rst_mode = cur_mode; seq4 = cur_seq4;
    @(posedge clk);
    clr = (cur_mode == 2'd1 && lstb && m_lpar) ||
          (cur_mode == 2'd2 && fstb && m_cnt == 3'd7) ||
          (cur_mode == 2'd3 && fstb && m_cnt[1:0] == 2'd3);
    m_acc = clr ? 32'd0 : m_acc + m_incr;
    if (we) begin
      if (sel == 2'd0) m_incr = {m_sh[3], m_sh[2], m_sh[1], d};
      else m_sh[sel] = d;
    end
    if (lstb) m_lpar = !m_lpar;
    m_pl = fstb && (cur_seq4 ? (m_cnt[1:0] == 2'd3) : (m_cnt == 3'd7));
    if (fstb) m_cnt = m_cnt + 3'd1;
    push_exp();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b0, 1'b0, 2'd0, 8'h00);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    drive(1'b0, 1'b0, 1'b1, sel, d);
  endtask

  // monitor: pops one expectation per cycle, mid-cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (phase !== e.ph) begin
        fails++;
        $display("FAIL %s phase_o actual=%h expected=%h", e.tag, phase, e.ph);
      end
      checks++;
      if (fseq !== e.fs) begin
        fails++;
        $display("FAIL R8 fseq_o actual=%0d expected=%0d", fseq, e.fs);
      end
      checks++;
      if (odd_even !== e.oe) begin
        fails++;
        $display("FAIL R9 odd_even_o actual=%b expected=%b", odd_even, e.oe);
      end
      checks++;
      if (seq_pulse !== e.pl) begin
        fails++;
        $display("FAIL R10 seq_pulse_o actual=%b expected=%b", seq_pulse, e.pl);
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    // R1: reset state
    rst_cycle();
    rst_cycle();
    // R2: free running with default increment
    cur_req = "R2";
    idle(40);
    // R3: staged bytes have no effect until byte 0
    cur_req = "R3";
    wr(2'd3, 8'h2A);
    idle(3);
    wr(2'd2, 8'h09);
    wr(2'd1, 8'h8A);
    idle(5);
    wr(2'd0, 8'hCB);
    idle(20);
    // R4: strobes ignored when no reset policy
    cur_req = "R4";
    cur_mode = 2'd0;
    for (int i = 0; i < 42; i++) drive(i % 3 == 0, i % 7 == 0, 1'b0, 2'd0, 8'h00);
    // R5: clear every second line
    cur_req = "R5";
    cur_mode = 2'd1;
    for (int i = 0; i < 60; i++) drive(i % 4 == 0, 1'b0, 1'b0, 2'd0, 8'h00);
    // R6: clear every eighth field, 8-field view
    cur_req = "R6";
    cur_mode = 2'd2;
    cur_seq4 = 1'b0;
    for (int i = 0; i < 100; i++) drive(1'b0, i % 5 == 0, 1'b0, 2'd0, 8'h00);
    // R7: clear every fourth field, 4-field view
    cur_req = "R7";
    cur_mode = 2'd3;
    cur_seq4 = 1'b1;
    for (int i = 0; i < 80; i++) drive(i % 3 == 0, i % 4 == 0, 1'b0, 2'd0, 8'h00);
    // R2: near-full increment wraps every cycle
    cur_req = "R2";
    cur_mode = 2'd0;
    wr(2'd3, 8'hFF);
    wr(2'd2, 8'hFF);
    wr(2'd1, 8'hFF);
    wr(2'd0, 8'hF0);
    idle(12);
    @(negedge clk); #1;
    @(negedge clk); #1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule